// File: doc/BRIEF.md
# Four-Way Merge-Tree Cost Sorter

The block accepts a batch of up to `N` wide products in one parallel load and returns the valid ones one per cycle in ascending order of cost. The cost of a product is the literal count kept in its lowest `CW` bits (6 by default, inside a 128-bit word). Each slot of the batch carries its own valid bit. Empty slots are treated as dearer than any real product, so they drain to the end of the order and never appear at the output.

Internally the loaded words sit in a two-row register buffer. A single compare-and-swap pass across the rows moves the cheaper item of each column into the near row. The buffer then feeds a balanced four-way tree of processing nodes with `log4(N)` levels. Each node compares its children in two pairs, then compares the two pair winners, and pushes the overall winner into a FIFO that feeds its parent. The root node drives a registered output stream with a valid flag and a last flag.

A controller with three states sequences the work. IDLE waits and moves to ORDER when `start` is seen. ORDER performs the row swap and always moves on to MERGE after one cycle. MERGE runs the tree and returns to IDLE once the root has consumed its full quota of `N` entries, pads included.

Top module: `quad_cost_sorter`

## Requirements
- R1: Valid products leave on `out_data` in non-decreasing order of cost, where the cost is bits `[CW-1:0]` of each product.
- R2: Products of equal cost leave in ascending slot order. Slot order is the order after the row pass of R3, and the left child wins every tie.
- R3: The buffer forms two rows, slots `0..N/2-1` (near) and `N/2..N-1` (far). During ORDER, slot `i` and slot `i+N/2` are exchanged only when the far item ranks strictly lower. Rank is the pair {invalid flag, cost}, so an invalid item ranks above every valid one.
- R4: A slot whose `in_vld` bit is 0 is never output, even when its cost bits are lower than those of valid slots. Exactly as many items leave as there were valid slots.
- R5: `out_last` is high together with the final valid output of a batch and at no other time. A batch with no valid slot produces no output and no `out_last`.
- R6: A `start` that arrives while `busy` is high is ignored, and the batch in flight completes unchanged.
- R7: For N=16 the final output and the fall of `busy` both come within TE = N + TL − 1 + Σ_{j=1..TL}(N/4^j + 1) = 24 cycles of the cycle in which `start` is taken.
- R8: After reset, `busy`, `out_valid` and `out_last` are all 0.
- R9: A batch started right after the previous one finishes gives a result that does not depend on that previous batch.
- R10: Each node below the root at level j has an output FIFO of N/4^j − 1 entries. It is never pushed when full and never popped when empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load `in_data`/`in_vld` and begin a sort (taken only when idle) |
| in_data | input | N*PW | Slot `i` occupies bits `[i*PW +: PW]` |
| in_vld | input | N | Per-slot valid flag |
| busy | output | 1 | High in ORDER and MERGE |
| out_valid | output | 1 | `out_data` holds a sorted product this cycle |
| out_data | output | PW | Sorted product |
| out_last | output | 1 | Marks the final valid product of the batch |

## Verification
The hardest situation to reach is one where the row swap of R3 shows at the output. Sorting by cost alone hides the swap, so the bench builds a batch in which a far-row item is cheaper than its near-row partner, and the displaced near item ties in cost with another near-row item that sits in a later slot. The tie order then shows whether the exchange took place. A second case that is hard to reach is a `start` pulse in the middle of MERGE. The bench injects it, with different data, several cycles into a running batch and then compares the whole output sequence with the one predicted for the original batch.

// File: rtl/qsort_pkg.sv
package qsort_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ORDER,
        ST_MERGE
    } qt_state_e;

    // index of the first node of tree level j (level 1 = leaves)
    function automatic int node_off(input int n, input int j);
        int s;
        s = 0;
        for (int k = 1; k < j; k++) s += n >> (2 * k);
        return s;
    endfunction

endpackage

// File: rtl/qt_fifo.sv
module qt_fifo #(
    parameter int W     = 129,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_q, wr_q;
    logic [NW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head  = mem[rd_q];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == NW'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R10

endmodule

// File: rtl/qt_node.sv
module qt_node #(
    parameter int ITW   = 129,
    parameter int CW    = 6,
    parameter int QUOTA = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           run,
    input  logic [ITW-1:0] hd_item [4],
    input  logic [3:0]     hd_has,
    input  logic [3:0]     hd_end,
    input  logic           out_full,
    output logic           fire,
    output logic [1:0]     sel,
    output logic [ITW-1:0] win,
    output logic           done
);
    localparam int KW = CW + 2;
    localparam int QW = $clog2(QUOTA + 1);

    // rank: absent child, then invalid pad, then cost; lower wins
    function automatic logic [KW-1:0] rank(input logic [ITW-1:0] it, input logic has);
        return {~has, ~it[ITW-1], it[CW-1:0]};
    endfunction

    logic [KW-1:0] k [4];
    logic [KW-1:0] kw1, kw2;
    logic [1:0]    w1, w2;
    logic          s1, s2, s3;   // comparator status: 1 when left > right
    logic [QW-1:0] cnt_q;

    always_comb begin
        for (int c = 0; c < 4; c++) k[c] = rank(hd_item[c], hd_has[c]);
        s1  = k[0] > k[1];
        w1  = s1 ? 2'd1 : 2'd0;
        kw1 = s1 ? k[1] : k[0];
        s2  = k[2] > k[3];
        w2  = s2 ? 2'd3 : 2'd2;
        kw2 = s2 ? k[3] : k[2];
        s3  = kw1 > kw2;
        sel = s3 ? w2 : w1;
        win = hd_item[sel];
    end

    assign done = (cnt_q == QW'(QUOTA));
    assign fire = run && !done && !out_full && (&(hd_has | hd_end)) && (|hd_has);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (clr)  cnt_q <= '0;
        else if (fire) cnt_q <= cnt_q + 1'b1;
    end

    AST_PICK_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> hd_has[sel]); // R1
    AST_TIE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && hd_has[0] && hd_has[1] && (hd_item[0][ITW-1] == hd_item[1][ITW-1])
         && (hd_item[0][CW-1:0] == hd_item[1][CW-1:0]) && !sel[1]) |-> (sel == 2'd0)); // R2
    AST_QUOTA_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done || $past(clr))); // R10

endmodule

// File: rtl/quad_cost_sorter.sv
module quad_cost_sorter
    import qsort_pkg::*;
#(
    parameter int N  = 16,
    parameter int PW = 128,
    parameter int CW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [N*PW-1:0] in_data,
    input  logic [N-1:0]    in_vld,
    output logic            busy,
    output logic            out_valid,
    output logic [PW-1:0]   out_data,
    output logic            out_last
);
    localparam int TL    = $clog2(N) / 2;
    localparam int HALF  = N / 2;
    localparam int ITW   = PW + 1;
    localparam int NODES = node_off(N, TL + 1);
    localparam int ROOT  = NODES - 1;
    localparam int VW    = $clog2(N + 1);

    function automatic logic [CW:0] bkey(input logic [ITW-1:0] it);
        return {~it[ITW-1], it[CW-1:0]};
    endfunction

    qt_state_e state_q, state_d;
    logic      run, start_acc;

    logic [ITW-1:0] slot [N];
    logic [N-1:0]   slot_used;

    logic           nd_fire [NODES];
    logic [1:0]     nd_sel  [NODES];
    logic [ITW-1:0] nd_win  [NODES];
    logic           nd_done [NODES];
    logic [ITW-1:0] f_head  [NODES];
    logic           f_empty [NODES];
    logic           f_full  [NODES];

    logic [VW-1:0]  vtotal_q, vcnt_q;
    logic           emit;

    // ---------------- controller ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_ORDER;
            ST_ORDER: state_d = ST_MERGE;
            ST_MERGE: if (nd_done[ROOT]) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        run       = (state_q == ST_MERGE);
        start_acc = (state_q == ST_IDLE) && start;
    end

    // ---------------- two-row input buffer ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) slot[i] <= '0;
        end else if (start_acc) begin
            for (int i = 0; i < N; i++) slot[i] <= {in_vld[i], in_data[i*PW +: PW]};
        end else if (state_q == ST_ORDER) begin
            for (int i = 0; i < HALF; i++) begin
                if (bkey(slot[i+HALF]) < bkey(slot[i])) begin
                    slot[i]      <= slot[i+HALF];
                    slot[i+HALF] <= slot[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_used <= '0;
        else if (start_acc) slot_used <= '0;
        else begin
            for (int s = 0; s < N; s++)
                if (nd_fire[s/4] && (nd_sel[s/4] == 2'(s % 4))) slot_used[s] <= 1'b1;
        end
    end

    // ---------------- merge tree ----------------
    for (genvar j = 1; j <= TL; j++) begin : g_lvl
        localparam int NP  = N >> (2 * j);
        localparam int OFF = node_off(N, j);
        for (genvar p = 0; p < NP; p++) begin : g_pe
            localparam int B = OFF + p;
            logic [ITW-1:0] hi [4];
            logic [3:0]     hh, he;

            for (genvar c = 0; c < 4; c++) begin : g_ch
                if (j == 1) begin : g_leaf
                    assign hi[c] = slot[4*p+c];
                    assign hh[c] = run && !slot_used[4*p+c];
                    assign he[c] = slot_used[4*p+c];
                end else begin : g_inner
                    localparam int CB = node_off(N, j - 1) + 4 * p + c;
                    assign hi[c] = f_head[CB];
                    assign hh[c] = !f_empty[CB];
                    assign he[c] = f_empty[CB] && nd_done[CB];
                end
            end

            qt_node #(.ITW(ITW), .CW(CW), .QUOTA(4 ** j)) u_node (
                .clk(clk), .rst_n(rst_n), .clr(start_acc), .run(run),
                .hd_item(hi), .hd_has(hh), .hd_end(he), .out_full(f_full[B]),
                .fire(nd_fire[B]), .sel(nd_sel[B]), .win(nd_win[B]), .done(nd_done[B])
            );

            if (j < TL) begin : g_q
                localparam int PB = node_off(N, j + 1) + p / 4;
                localparam logic [1:0] PS = 2'(p % 4);
                qt_fifo #(.W(ITW), .DEPTH((N >> (2 * j)) - 1)) u_fifo (
                    .clk(clk), .rst_n(rst_n), .clr(start_acc),
                    .push(nd_fire[B]), .din(nd_win[B]),
                    .pop(nd_fire[PB] && (nd_sel[PB] == PS)),
                    .head(f_head[B]), .empty(f_empty[B]), .full(f_full[B])
                );
            end else begin : g_top
                assign f_head[B]  = '0;
                assign f_empty[B] = 1'b1;
                assign f_full[B]  = 1'b0;
            end
        end
    end

    // ---------------- output stage ----------------
    assign emit = nd_fire[ROOT] && nd_win[ROOT][ITW-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_data  <= '0;
            vcnt_q    <= '0;
            vtotal_q  <= '0;
        end else begin
            out_valid <= emit;
            out_last  <= emit && (vcnt_q + 1'b1 == vtotal_q);
            if (emit) out_data <= nd_win[ROOT][PW-1:0];
            if (start_acc) begin
                vcnt_q   <= '0;
                vtotal_q <= VW'($countones(in_vld));
            end else if (emit) begin
                vcnt_q <= vcnt_q + 1'b1;
            end
        end
    end

    // ordering monitor state
    logic          prev_ok_q;
    logic [CW-1:0] prev_cost_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_ok_q   <= 1'b0;
            prev_cost_q <= '0;
        end else if (start_acc) begin
            prev_ok_q <= 1'b0;
        end else if (out_valid) begin
            prev_ok_q   <= 1'b1;
            prev_cost_q <= out_data[CW-1:0];
        end
    end

    AST_SORTED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && prev_ok_q) |-> (out_data[CW-1:0] >= prev_cost_q)); // R1
    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !out_valid); // R4
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MERGE && start) |=> (state_q != ST_ORDER)); // R6

endmodule

// File: tb/sim_quad_cost_sorter.sv
`timescale 1ns/1ps
module sim_quad_cost_sorter;
    localparam int N  = 16;
    localparam int PW = 128;
    localparam int CW = 6;
    localparam int TL = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [N*PW-1:0] in_data = '0;
    logic [N-1:0]    in_vld = '0;
    logic            busy, out_valid, out_last;
    logic [PW-1:0]   out_data;

    int errors = 0;
    int checks = 0;

    logic [PW-1:0] tv_data [N];
    logic          tv_vld  [N];
    logic [PW-1:0] exp_q [N];
    int            nexp;
    logic [PW-1:0] got_q [N];
    int            ngot;

    always #10 clk = ~clk;

    quad_cost_sorter #(.N(N), .PW(PW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .in_data(in_data), .in_vld(in_vld),
        .busy(busy), .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
    );

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: run did not end, actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] mk(input int id, input int cost);
        return (PW'(id) << 8) | PW'(cost);
    endfunction

    // reference: row pass then stable selection by cost over valid slots
    task automatic build_expect();
        logic [PW-1:0] d [N];
        logic          v [N];
        for (int i = 0; i < N; i++) begin d[i] = tv_data[i]; v[i] = tv_vld[i]; end
        for (int i = 0; i < N/2; i++) begin
            logic [CW:0] kn, kf;
            kn = {~v[i], d[i][CW-1:0]};
            kf = {~v[i+N/2], d[i+N/2][CW-1:0]};
            if (kf < kn) begin
                logic [PW-1:0] td; logic tvv;
                td = d[i]; d[i] = d[i+N/2]; d[i+N/2] = td;
                tvv = v[i]; v[i] = v[i+N/2]; v[i+N/2] = tvv;
            end
        end
        nexp = 0;
        for (int c = 0; c < (1 << CW); c++)
            for (int i = 0; i < N; i++)
                if (v[i] && d[i][CW-1:0] == CW'(c)) begin exp_q[nexp] = d[i]; nexp++; end
    endtask

    task automatic drive_inputs();
        for (int i = 0; i < N; i++) begin
            in_data[i*PW +: PW] = tv_data[i];
            in_vld[i]           = tv_vld[i];
        end
    endtask

    task automatic run_batch(input string tag, input int inject_at);
        int  last_pos, nlast, last_smp, idle_smp;
        bit  seq_ok;
        build_expect();
        ngot = 0; nlast = 0; last_pos = -1; last_smp = -1; idle_smp = -1;
        @(negedge clk);
        drive_inputs();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int smp = 1; smp <= 40; smp++) begin
            if (smp > 1) @(negedge clk);
            start = 1'b0;
            if (out_valid) begin
                if (ngot < N) got_q[ngot] = out_data;
                if (out_last) begin nlast++; last_pos = ngot; end
                ngot++;
                last_smp = smp;
            end
            if (!busy && idle_smp < 0) idle_smp = smp;
            if (smp == inject_at) begin
                for (int i = 0; i < N; i++) in_data[i*PW +: PW] = mk(200 + i, 0);
                in_vld = '1;
                start  = 1'b1;
            end
        end
        seq_ok = (ngot == nexp);
        for (int i = 0; i < nexp && i < ngot && i < N; i++)
            if (got_q[i] !== exp_q[i]) begin
                seq_ok = 1'b0;
                $display("  %s mismatch at %0d: got %0h exp %0h", tag, i, got_q[i], exp_q[i]);
            end
        chk(ngot == nexp, {tag, " R4 count"}, ngot, nexp);
        chk(seq_ok, {tag, " R1 R2 order"}, seq_ok, 1);
        if (nexp > 0) begin
            chk(nlast == 1 && last_pos == nexp - 1, {tag, " R5 last position"}, last_pos, nexp - 1);
            chk(last_smp > 0 && last_smp <= 24, {tag, " R7 final output cycle"}, last_smp, 24);
        end else begin
            chk(nlast == 0, {tag, " R5 no last"}, nlast, 0);
        end
        chk(idle_smp > 0 && idle_smp <= 24, {tag, " R7 busy drop cycle"}, idle_smp, 24);
    endtask

    task automatic t_reset();
        #1;
        chk(busy == 1'b0, "R8 busy", busy, 0);
        chk(out_valid == 1'b0, "R8 out_valid", out_valid, 0);
        chk(out_last == 1'b0, "R8 out_last", out_last, 0);
    endtask

    task automatic t_reversed();
        for (int i = 0; i < N; i++) begin tv_data[i] = mk(i, 60 - 3 * i); tv_vld[i] = 1'b1; end
        run_batch("reversed R1", 0);
    endtask

    task automatic t_scrambled(input int mul, input int add, input string tag);
        for (int i = 0; i < N; i++) begin tv_data[i] = mk(i + add, (i * mul + add) % 64); tv_vld[i] = 1'b1; end
        run_batch(tag, 0);
    endtask

    task automatic t_all_equal();
        for (int i = 0; i < N; i++) begin tv_data[i] = mk(i, 17); tv_vld[i] = 1'b1; end
        run_batch("ties R2", 0);
    endtask

    task automatic t_row_swap();
        for (int i = 0; i < N; i++) begin tv_data[i] = mk(i, 40); tv_vld[i] = 1'b1; end
        tv_data[0] = mk(100, 9);   // near row, displaced by its far partner
        tv_data[8] = mk(101, 2);   // far row, cheaper: swaps into slot 0
        tv_data[3] = mk(102, 9);   // ties with the displaced item, lands before it
        run_batch("row pass R3", 0);
        chk(got_q[1] === mk(102, 9), "R3 swapped item after tie partner", got_q[1][15:8], 102);
    endtask

    task automatic t_underfilled();
        for (int i = 0; i < N; i++) begin
            tv_vld[i]  = (i % 2 == 0);
            tv_data[i] = tv_vld[i] ? mk(i, 30 - i) : mk(i, 0);
        end
        run_batch("underfilled R4", 0);
    endtask

    task automatic t_empty();
        for (int i = 0; i < N; i++) begin tv_data[i] = mk(i, 1); tv_vld[i] = 1'b0; end
        run_batch("empty R5", 0);
    endtask

    task automatic t_single_max();
        for (int i = 0; i < N; i++) begin tv_data[i] = mk(i, 0); tv_vld[i] = 1'b0; end
        tv_data[15] = mk(15, 63); tv_vld[15] = 1'b1;
        run_batch("single max R5", 0);
    endtask

    task automatic t_start_busy();
        for (int i = 0; i < N; i++) begin tv_data[i] = mk(i + 50, (i * 13 + 7) % 64); tv_vld[i] = 1'b1; end
        run_batch("start while busy R6", 5);
    endtask

    initial begin
        for (int i = 0; i < N; i++) got_q[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reversed();
        t_scrambled(23, 5, "scrambled R1");
        t_all_equal();
        t_row_swap();
        t_underfilled();
        t_empty();
        t_single_max();
        t_start_busy();
        t_scrambled(29, 3, "back to back R9");
        t_scrambled(29, 3, "repeat R9");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule